// File: doc/BRIEF.md
# Banked Data Pointer Register File

This block holds eight 16-bit data pointers for an 8051-style core. Only one pointer is active at a time. A bank-select special function register chooses it from its low three bits. The active pointer has two views. On the SFR bus its low byte sits at address 0x82 and its high byte at 0x83. On a direct core-side port the address generator sees the whole 16-bit value and can ask for an increment or a full load. Both views are windows onto the same storage, so a change made through one is seen through the other on the next cycle.

The storage is a byte array in which bank n occupies bytes 2n (low) and 2n+1 (high). The select register is a full byte: all eight bits are kept and read back, but only bits [2:0] choose the bank. Every update is registered. Reads on the SFR bus are combinational from the current state.

Top module: `dpf_bank_file`

## Requirements
- R1: After reset the active bank is 0, every stored pointer byte is 0x00, and the select register reads 0x00.
- R2: An SFR write to 0x92 stores all eight data bits, and a read of 0x92 returns them. Only bits [2:0] select the bank; bits [7:3] have no effect on which pointer is active.
- R3: Bank n keeps its low byte at store offset 2n and its high byte at 2n+1. With bank k active, reads of 0x82 and 0x83 return those two bytes, and the core port shows them as {high, low}.
- R4: An SFR write to 0x82 or 0x83 replaces only that byte of the active bank. From the next cycle the new value shows on the core port.
- R5: A core load request replaces the whole active pointer with the load value. From the next cycle the SFR reads of 0x82 and 0x83 return it.
- R6: A core increment adds one to the active pointer with carry from the low byte into the high byte, and 0xFFFF wraps to 0x0000. Pointers of the other banks are unchanged.
- R7: Load has priority over increment. A core request in the same cycle as an SFR write to 0x82 or 0x83 wins, and that SFR byte write is dropped.
- R8: When the select register is written in the same cycle as a pointer update, the update goes to the bank that was active before the write.
- R9: Reads of any other SFR address return 0x00, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | SFR bus address |
| sfr_we | input | 1 | SFR bus write enable |
| sfr_wdata | input | 8 | SFR bus write data |
| sfr_rdata | output | 8 | SFR bus read data for the current address |
| ptr_value | output | 16 | Active pointer for the core address generator |
| ptr_inc | input | 1 | Increment the active pointer |
| ptr_load | input | 1 | Load the active pointer with ptr_load_val |
| ptr_load_val | input | 16 | Value for a load request |

## Verification
The bench goes after four corner cases.

- Increment carries at 0x00FF and 0xFFFF. A design that incremented each byte on its own would leave the high byte stale or fail to wrap.
- A select write lands in the same cycle as a load. A design that routed the load through the new bank number would corrupt the wrong pointer, and a later revisit of both banks exposes it.
- The upper select bits are set. A design that decoded more than three bits would land on a bank it does not have or read garbage.
- Priority collisions are driven: load against increment, and core request against SFR byte write. A wrong priority leaves a pointer that the per-cycle reference model rejects.

// File: rtl/dpf_pkg.sv
package dpf_pkg;
  typedef logic [7:0]  byte_t;
  typedef logic [15:0] word_t;

  // which path updates the active pointer this cycle
  typedef enum logic [1:0] {
    UPD_NONE = 2'd0,
    UPD_SFR  = 2'd1,
    UPD_INC  = 2'd2,
    UPD_LOAD = 2'd3
  } upd_src_e;
endpackage

// File: rtl/dpf_sel_reg.sv
module dpf_sel_reg
  import dpf_pkg::*;
#(
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  byte_t             wdata,
  output byte_t             sel_byte,
  output logic [BANK_W-1:0] bank
);
  byte_t sel_d, sel_q;

  always_comb begin
    sel_d = sel_q;
    if (wr_en) sel_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  assign sel_byte = sel_q;
  assign bank     = sel_q[BANK_W-1:0];
endmodule

// File: rtl/dpf_ptr_next.sv
module dpf_ptr_next
  import dpf_pkg::*;
(
  input  word_t      cur,
  input  logic       sfr_lo_we,
  input  logic       sfr_hi_we,
  input  byte_t      sfr_wdata,
  input  logic       inc,
  input  logic       load,
  input  word_t      load_val,
  output logic [1:0] wr_mask,
  output word_t      wr_word
);
  upd_src_e src;

  always_comb begin
    if (load)                        src = UPD_LOAD;
    else if (inc)                    src = UPD_INC;
    else if (sfr_lo_we || sfr_hi_we) src = UPD_SFR;
    else                             src = UPD_NONE;
  end

  always_comb begin
    wr_mask = 2'b00;
    wr_word = cur;
    unique case (src)
      UPD_LOAD: begin
        wr_mask = 2'b11;
        wr_word = load_val;
      end
      UPD_INC: begin
        wr_mask = 2'b11;
        wr_word = cur + 16'd1;
      end
      UPD_SFR: begin
        wr_mask = {sfr_hi_we, sfr_lo_we};
        if (sfr_lo_we) wr_word[7:0]  = sfr_wdata;
        if (sfr_hi_we) wr_word[15:8] = sfr_wdata;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dpf_store.sv
module dpf_store
  import dpf_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bank,
  input  logic [1:0]        wr_mask,
  input  word_t             wr_word,
  output word_t             rd_word
);
  localparam int NBYTES = 2 * NUM_BANKS;

  logic [NBYTES*8-1:0] flat;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    localparam int OWNER = i / 2;
    localparam int HALF  = i % 2;
    byte_t q, d;
    logic  en;

    assign en = wr_mask[HALF] && (bank == BANK_W'(OWNER));

    always_comb begin
      d = q;
      if (en) d = wr_word[HALF*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign flat[i*8 +: 8] = q;
  end

  assign rd_word = flat[int'(bank)*16 +: 16];
endmodule

// File: rtl/dpf_bank_file.sv
module dpf_bank_file
  import dpf_pkg::*;
#(
  parameter int         NUM_BANKS = 8,
  parameter logic [7:0] SEL_ADDR  = 8'h92,
  parameter logic [7:0] LO_ADDR   = 8'h82,
  parameter logic [7:0] HI_ADDR   = 8'h83
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  sfr_addr,
  input  logic        sfr_we,
  input  logic [7:0]  sfr_wdata,
  output logic [7:0]  sfr_rdata,
  output logic [15:0] ptr_value,
  input  logic        ptr_inc,
  input  logic        ptr_load,
  input  logic [15:0] ptr_load_val
);
  localparam int BANK_W = $clog2(NUM_BANKS);

  logic              sel_wr, lo_wr, hi_wr;
  byte_t             sel_byte;
  logic [BANK_W-1:0] bank;
  logic [1:0]        wr_mask;
  word_t             wr_word, cur;

  assign sel_wr = sfr_we && (sfr_addr == SEL_ADDR);
  assign lo_wr  = sfr_we && (sfr_addr == LO_ADDR);
  assign hi_wr  = sfr_we && (sfr_addr == HI_ADDR);

  dpf_sel_reg #(.BANK_W(BANK_W)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (sel_wr),
    .wdata    (sfr_wdata),
    .sel_byte (sel_byte),
    .bank     (bank)
  );

  dpf_ptr_next u_next (
    .cur       (cur),
    .sfr_lo_we (lo_wr),
    .sfr_hi_we (hi_wr),
    .sfr_wdata (sfr_wdata),
    .inc       (ptr_inc),
    .load      (ptr_load),
    .load_val  (ptr_load_val),
    .wr_mask   (wr_mask),
    .wr_word   (wr_word)
  );

  dpf_store #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .bank    (bank),
    .wr_mask (wr_mask),
    .wr_word (wr_word),
    .rd_word (cur)
  );

  assign ptr_value = cur;

  always_comb begin
    if (sfr_addr == SEL_ADDR)     sfr_rdata = sel_byte;
    else if (sfr_addr == LO_ADDR) sfr_rdata = cur[7:0];
    else if (sfr_addr == HI_ADDR) sfr_rdata = cur[15:8];
    else                          sfr_rdata = 8'h00;
  end
endmodule

// File: rtl/dpf_checker.sv
module dpf_checker #(
  parameter logic [7:0] SEL_ADDR = 8'h92,
  parameter logic [7:0] LO_ADDR  = 8'h82,
  parameter logic [7:0] HI_ADDR  = 8'h83
) (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  sfr_addr,
  input logic        sfr_we,
  input logic [7:0]  sfr_wdata,
  input logic [15:0] ptr_value,
  input logic        ptr_inc,
  input logic        ptr_load,
  input logic [15:0] ptr_load_val,
  input logic [7:0]  sel_byte
);
  logic sel_w, lo_w, hi_w;
  assign sel_w = sfr_we && (sfr_addr == SEL_ADDR);
  assign lo_w  = sfr_we && (sfr_addr == LO_ADDR);
  assign hi_w  = sfr_we && (sfr_addr == HI_ADDR);

  // R2: select byte holds what was written
  a_r2_sel_store: assert property (@(posedge clk) disable iff (!rst_n)
    sel_w |=> sel_byte == $past(sfr_wdata));

  // R5 / R7: load wins and lands in the (unchanged) active bank
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_load && !sel_w) |=> ptr_value == $past(ptr_load_val));

  // R6: increment with carry
  a_r6_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_inc && !ptr_load && !sel_w) |=> ptr_value == $past(ptr_value) + 16'd1);

  // R4: SFR low-byte write reaches the core view
  a_r4_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_w && !ptr_inc && !ptr_load) |=>
      (ptr_value[7:0] == $past(sfr_wdata)) && (ptr_value[15:8] == $past(ptr_value[15:8])));

  // R9: no relevant write and no core request keeps the pointer
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_w && !lo_w && !hi_w && !ptr_inc && !ptr_load) |=> $stable(ptr_value));
endmodule

bind dpf_bank_file dpf_checker #(
  .SEL_ADDR (SEL_ADDR),
  .LO_ADDR  (LO_ADDR),
  .HI_ADDR  (HI_ADDR)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sfr_addr     (sfr_addr),
  .sfr_we       (sfr_we),
  .sfr_wdata    (sfr_wdata),
  .ptr_value    (ptr_value),
  .ptr_inc      (ptr_inc),
  .ptr_load     (ptr_load),
  .ptr_load_val (ptr_load_val),
  .sel_byte     (sel_byte)
);

// File: tb/test_dpf_bank_file.sv
`timescale 1ns/1ps
module test_dpf_bank_file;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  sfr_addr;
  logic        sfr_we;
  logic [7:0]  sfr_wdata;
  logic [7:0]  sfr_rdata;
  logic [15:0] ptr_value;
  logic        ptr_inc;
  logic        ptr_load;
  logic [15:0] ptr_load_val;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference model state
  int mdl_mem [16];
  int mdl_sel;

  always #2.5 clk = ~clk;

  dpf_bank_file i_dpf_bank_file (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ptr_value(ptr_value),
    .ptr_inc(ptr_inc), .ptr_load(ptr_load), .ptr_load_val(ptr_load_val)
  );

  function automatic int mdl_ptr();
    int b = mdl_sel % 8;
    return mdl_mem[2*b+1] * 256 + mdl_mem[2*b];
  endfunction

  function automatic int mdl_read(int a);
    int p = mdl_ptr();
    if (a == 'h92) return mdl_sel;
    if (a == 'h82) return p % 256;
    if (a == 'h83) return p / 256;
    return 0;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model at the edge, compare at next negedge
  task automatic cyc(string req, int a, bit we, int wd, bit inc, bit ld, int lv);
    int b, p;
    sfr_addr = 8'(a); sfr_we = we; sfr_wdata = 8'(wd);
    ptr_inc = inc; ptr_load = ld; ptr_load_val = 16'(lv);
    @(posedge clk);
    b = mdl_sel % 8;
    p = mdl_ptr();
    if (ld) begin
      mdl_mem[2*b] = lv % 256; mdl_mem[2*b+1] = (lv / 256) % 256;
    end else if (inc) begin
      p = (p + 1) % 65536;
      mdl_mem[2*b] = p % 256; mdl_mem[2*b+1] = p / 256;
    end else if (we && a == 'h82) mdl_mem[2*b]   = wd;
    else if (we && a == 'h83)     mdl_mem[2*b+1] = wd;
    if (we && a == 'h92) mdl_sel = wd;
    @(negedge clk);
    sfr_we = 0; ptr_inc = 0; ptr_load = 0;
    check({req, " ptr_value"}, int'(ptr_value), mdl_ptr());
    check({req, " sfr_rdata"}, int'(sfr_rdata), mdl_read(a));
  endtask

  task automatic rd(string req, int a, int exp);
    sfr_addr = 8'(a);
    #1;
    check(req, int'(sfr_rdata), exp);
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sfr_addr = 8'h92; sfr_we = 0; sfr_wdata = 0;
    ptr_inc = 0; ptr_load = 0; ptr_load_val = 0;
    foreach (mdl_mem[i]) mdl_mem[i] = 0;
    mdl_sel = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sel", int'(sfr_rdata), 0);
    check("R1 ptr", int'(ptr_value), 0);
    rst_n = 1;
    @(negedge clk);

    // R3 / R4 fill bank k with bytes 2k, 2k+1 through the SFR view
    for (int k = 0; k < 8; k++) begin
      cyc("R3 sel", 'h92, 1, k, 0, 0, 0);
      cyc("R4 lo", 'h82, 1, 2*k, 0, 0, 0);
      cyc("R4 hi", 'h83, 1, 2*k+1, 0, 0, 0);
    end
    for (int k = 0; k < 8; k++) begin
      cyc("R3 pick", 'h92, 1, k, 0, 0, 0);
      rd("R3 low byte", 'h82, 2*k);
      rd("R3 high byte", 'h83, 2*k+1);
      check("R3 core view", int'(ptr_value), (2*k+1)*256 + 2*k);
    end

    // R2 upper select bits stored but ignored
    cyc("R2 upper bits", 'h92, 1, 'hF9, 0, 0, 0);
    check("R2 bank1", int'(ptr_value), 'h0302);
    rd("R2 readback", 'h92, 'hF9);

    // R5 load, read back through SFR
    cyc("R5 load", 'h82, 0, 0, 0, 1, 'hABCD);
    rd("R5 lo", 'h82, 'hCD);
    rd("R5 hi", 'h83, 'hAB);

    // R6 carry and wrap
    cyc("R6 set", 'h82, 0, 0, 0, 1, 'h00FF);
    cyc("R6 carry", 'h83, 0, 0, 1, 0, 0);
    check("R6 carry", int'(ptr_value), 'h0100);
    cyc("R6 set", 'h82, 0, 0, 0, 1, 'hFFFF);
    cyc("R6 wrap", 'h82, 0, 0, 1, 0, 0);
    check("R6 wrap", int'(ptr_value), 0);
    cyc("R6 other bank", 'h92, 1, 2, 0, 0, 0);
    check("R6 bank2 untouched", int'(ptr_value), 'h0504);

    // R7 priorities
    cyc("R7 load over inc", 'h82, 0, 0, 1, 1, 'h1234);
    check("R7 load over inc", int'(ptr_value), 'h1234);
    cyc("R7 inc over sfr", 'h82, 1, 'h77, 1, 0, 0);
    check("R7 inc over sfr", int'(ptr_value), 'h1235);
    cyc("R7 load over sfr", 'h83, 1, 'h77, 0, 1, 'h4321);
    check("R7 load over sfr", int'(ptr_value), 'h4321);

    // R8 select write with same-cycle load and inc go to old bank
    cyc("R8 sel+load", 'h92, 1, 5, 0, 1, 'hBEEF);
    check("R8 new bank view", int'(ptr_value), 'h0B0A);
    cyc("R8 back", 'h92, 1, 2, 0, 0, 0);
    check("R8 old bank got load", int'(ptr_value), 'hBEEF);
    cyc("R8 sel+inc", 'h92, 1, 6, 1, 0, 0);
    cyc("R8 back", 'h92, 1, 2, 0, 0, 0);
    check("R8 old bank got inc", int'(ptr_value), 'hBEF0);

    // R9 other addresses
    cyc("R9 write other", 'h90, 1, 'hA5, 0, 0, 0);
    rd("R9 read other", 'h90, 0);
    rd("R9 sel kept", 'h92, 2);
    check("R9 ptr kept", int'(ptr_value), 'hBEF0);

    // sweep all banks against the model
    for (int k = 0; k < 8; k++) cyc("R3 sweep", 'h92, 1, k, 0, 0, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule